// File: doc/BRIEF.md
# Synthesizer Divider Configuration Port

This block holds the programming word of a clock synthesizer: a 9-bit feedback divider value, a 2-bit output divider code and an 8-bit spread-spectrum control byte. These can be set from two sources, a set of parallel pins or a write-only I2C slave. A mode pin chooses between them. While the mode pin is low, the parallel pins pass straight through to the live outputs. When the mode pin rises, the last pin values are frozen.

While the mode pin is high, a serial master can write to the block. A write consists of the slave address, one ignored filler byte and three payload bytes. The payload lands in a shadow copy first. It reaches the live outputs only when a STOP arrives after all four data bytes. The block does not acknowledge any byte beyond the fourth, and those bytes are discarded. SCL and SDA are sampled by a system clock that runs at least eight times faster than SCL. The only thing the block drives on the bus is an open-drain pull-down on SDA.

Top module: `synth_cfg_port`

## Requirements
- R1: After reset the feedback divider reads 256 (only bit 8 set), the output divider code reads 0, the spread byte reads 0 and SDA is released.
- R2: The block acknowledges an address byte whose bits 7..1 are 1,1,0,1,1,`addr_sel_i`,0 and whose bit 0 (R/W) is 0. To acknowledge, it pulls SDA low from the SCL low phase before the ninth rising edge until the SCL falling edge that follows it. The pull-down changes only while SCL is low.
- R3: If the address does not match, or if R/W is 1, the block gives no acknowledge to that byte or to any later byte. The live outputs stay unchanged.
- R4: After a matching address, the block acknowledges four data bytes. The first is a filler byte and is ignored. The second, MSB first, carries output divider code bits 1..0 and then feedback divider bits 8..3. The third carries feedback divider bits 2..0 in bits 7..5, and its bits 4..0 are unused. The fourth is the spread byte, taken as is.
- R5: The live outputs take the shadow values only after a STOP that ends a write with at least four data bytes. Before that STOP they keep their old values.
- R6: A STOP after fewer than four data bytes changes no live output.
- R7: The block does not acknowledge data bytes five and later, and they do not change what gets committed.
- R8: While `ser_mode_i` is low, the feedback divider and output divider code follow `par_fb_i` and `par_od_i`, one clock later.
- R9: After `ser_mode_i` rises, the outputs hold the last pin values until `ser_mode_i` falls or a serial write commits.
- R10: While `ser_mode_i` is low, the block does not acknowledge a serial write, and the write commits nothing.
- R11: A repeated START in the middle of a transfer restarts the address and byte count. Only the new transfer can commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_sel_i | input | 1 | Chooses address bit 2 |
| ser_mode_i | input | 1 | 0: parallel pins drive the outputs; 1: hold, serial writes allowed |
| par_fb_i | input | 9 | Parallel feedback divider value |
| par_od_i | input | 2 | Parallel output divider code |
| fb_div_o | output | 9 | Live feedback divider |
| out_div_o | output | 2 | Live output divider code |
| spread_o | output | 8 | Live spread-spectrum control byte |

## Verification
A parallel pin change shows up on the outputs at the next rising clock edge. The bench therefore changes pins on a falling edge and samples two falling edges later.

Each bus line goes through two synchronizer flops and one edge-detect flop. Because of this, the acknowledge pull-down appears about four system clocks after the SCL falling edge. A commit appears about five clocks after the SDA rise that forms the STOP.

The master model holds each SCL phase for twenty system clocks. It samples the acknowledge in the middle of the ninth SCL high phase, and it reads the live outputs ten clocks after the STOP. All of these points are well past every latency listed here.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int FB_W   = 9;
  localparam int OD_W   = 2;
  localparam int SS_W   = 8;
  localparam int BYTE_W = 8;
  // filler plus three payload bytes
  localparam int NUM_DATA   = 4;
  localparam int NUM_SHADOW = 3;
  localparam logic [4:0] ADDR_TOP = 5'b11011;
  localparam logic [FB_W-1:0] FB_RESET = 9'h100;

  typedef enum logic {PH_BITS, PH_ACK} bus_phase_t;
  typedef logic [NUM_SHADOW-1:0][BYTE_W-1:0] shadow_t;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int  STAGES = 2,
  parameter logic IDLE  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk)
        if (rst) chain <= IDLE;
        else     chain <= d_i;
    end else begin : g_many
      always_ff @(posedge clk)
        if (rst) chain <= {STAGES{IDLE}};
        else     chain <= {chain[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk)
    if (rst) prev <= IDLE;
    else     prev <= chain[STAGES-1];

  assign q_o    = chain[STAGES-1];
  assign rise_o = chain[STAGES-1] & ~prev;
  assign fall_o = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/i2c_wr_rx.sv
module i2c_wr_rx
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    scl_i,
  input  logic    sda_i,
  input  logic    addr_sel_i,
  input  logic    accept_i,
  output logic    sda_pull_o,
  output logic    commit_o,
  output shadow_t shadow_o
);
  localparam int BIT_CW  = $clog2(BYTE_W + 1);
  localparam int IDX_W   = $clog2(NUM_DATA + 2);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_DATA);
  localparam logic [IDX_W-1:0] IDX_OVER = IDX_W'(NUM_DATA + 1);

  logic scl_q, scl_rise, scl_fall;
  logic sda_q, sda_rise, sda_fall;

  line_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_scl (
    .clk(clk), .rst(rst), .d_i(scl_i), .q_o(scl_q), .rise_o(scl_rise), .fall_o(scl_fall));
  line_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sda (
    .clk(clk), .rst(rst), .d_i(sda_i), .q_o(sda_q), .rise_o(sda_rise), .fall_o(sda_fall));

  logic start_det, stop_det;
  assign start_det = sda_fall & scl_q;
  assign stop_det  = sda_rise & scl_q;

  bus_phase_t        phase;
  logic              busy;
  logic              loaded;
  logic [BIT_CW-1:0] bit_cnt;
  logic [IDX_W-1:0]  byte_idx;
  logic [BYTE_W-1:0] shreg;
  logic              addr_hit;

  assign addr_hit = (shreg[7:1] == {ADDR_TOP, addr_sel_i, 1'b0}) && !shreg[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_BITS;
      busy       <= 1'b0;
      loaded     <= 1'b0;
      bit_cnt    <= '0;
      byte_idx   <= '0;
      shreg      <= '0;
      sda_pull_o <= 1'b0;
      commit_o   <= 1'b0;
      shadow_o   <= '0;
    end else begin
      commit_o <= 1'b0;
      if (start_det) begin
        busy       <= 1'b1;
        loaded     <= 1'b0;
        phase      <= PH_BITS;
        bit_cnt    <= '0;
        byte_idx   <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_det) begin
        commit_o   <= busy & loaded & accept_i;
        busy       <= 1'b0;
        loaded     <= 1'b0;
        sda_pull_o <= 1'b0;
      end else if (busy) begin
        if (phase == PH_BITS) begin
          if (scl_rise && bit_cnt < BIT_CW'(BYTE_W)) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_q};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && bit_cnt == BIT_CW'(BYTE_W)) begin
            phase <= PH_ACK;
            if (byte_idx == '0) begin
              if (addr_hit && accept_i) sda_pull_o <= 1'b1;
              else                      busy       <= 1'b0;
            end else if (byte_idx <= IDX_LAST) begin
              sda_pull_o <= 1'b1;
              case (byte_idx)
                IDX_W'(2): shadow_o[0] <= shreg;
                IDX_W'(3): shadow_o[1] <= shreg;
                IDX_W'(4): shadow_o[2] <= shreg;
                default: ;
              endcase
              if (byte_idx == IDX_LAST) loaded <= 1'b1;
            end
          end
        end else if (scl_fall) begin
          phase      <= PH_BITS;
          sda_pull_o <= 1'b0;
          bit_cnt    <= '0;
          if (byte_idx != IDX_OVER) byte_idx <= byte_idx + 1'b1;
        end
      end
    end
  end

  // R2
  pull_edge_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_pull_o != $past(sda_pull_o)) |-> !scl_q);
  // R7
  no_ack_past_last_chk: assert property (@(posedge clk) disable iff (rst)
    sda_pull_o |-> (byte_idx <= IDX_LAST));
  // R10
  commit_needs_accept_chk: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> $past(accept_i));
  // R6
  commit_needs_load_chk: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> $past(loaded));
endmodule

// File: rtl/cfg_live.sv
module cfg_live
  import synth_cfg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            ser_mode_i,
  input  logic [FB_W-1:0] par_fb_i,
  input  logic [OD_W-1:0] par_od_i,
  input  logic            commit_i,
  input  shadow_t         shadow_i,
  output logic [FB_W-1:0] fb_div_o,
  output logic [OD_W-1:0] out_div_o,
  output logic [SS_W-1:0] spread_o
);
  logic [FB_W-1:0] sh_fb;
  logic [OD_W-1:0] sh_od;

  // payload byte 0: od[1:0], fb[8:3]; byte 1: fb[2:0] in bits 7..5
  assign sh_od = shadow_i[0][7:6];
  assign sh_fb = {shadow_i[0][5:0], shadow_i[1][7:5]};

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_div_o  <= FB_RESET;
      out_div_o <= '0;
      spread_o  <= '0;
    end else if (!ser_mode_i) begin
      fb_div_o  <= par_fb_i;
      out_div_o <= par_od_i;
    end else if (commit_i) begin
      fb_div_o  <= sh_fb;
      out_div_o <= sh_od;
      spread_o  <= shadow_i[2];
    end
  end

  // R8
  par_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ser_mode_i)) |-> (fb_div_o == $past(par_fb_i) && out_div_o == $past(par_od_i)));
  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ser_mode_i) && !$past(commit_i)) |-> ($stable(fb_div_o) && $stable(out_div_o)));
  // R5
  spread_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(commit_i)) |-> $stable(spread_o));
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_pull_o,
  input  logic            addr_sel_i,
  input  logic            ser_mode_i,
  input  logic [FB_W-1:0] par_fb_i,
  input  logic [OD_W-1:0] par_od_i,
  output logic [FB_W-1:0] fb_div_o,
  output logic [OD_W-1:0] out_div_o,
  output logic [SS_W-1:0] spread_o
);
  logic    commit;
  shadow_t shadow;

  i2c_wr_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .addr_sel_i(addr_sel_i), .accept_i(ser_mode_i),
    .sda_pull_o(sda_pull_o), .commit_o(commit), .shadow_o(shadow));

  cfg_live u_live (
    .clk(clk), .rst(rst), .ser_mode_i(ser_mode_i),
    .par_fb_i(par_fb_i), .par_od_i(par_od_i),
    .commit_i(commit), .shadow_i(shadow),
    .fb_div_o(fb_div_o), .out_div_o(out_div_o), .spread_o(spread_o));

  // R1
  reset_release_chk: assert property (@(posedge clk)
    $past(rst) |-> (!sda_pull_o && spread_o == '0));
endmodule

// File: tb/test_synth_cfg_port.sv
`timescale 1ns/1ps
module test_synth_cfg_port;
  localparam int H = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, sda_m = 1'b1;
  logic addr_sel = 1'b0, ser_mode = 1'b1;
  logic [8:0] par_fb = '0;
  logic [1:0] par_od = '0;
  logic sda_pull;
  logic [8:0] fb;
  logic [1:0] od;
  logic [7:0] ss;
  logic sda_line;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  synth_cfg_port i_synth_cfg_port (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .addr_sel_i(addr_sel), .ser_mode_i(ser_mode), .par_fb_i(par_fb), .par_od_i(par_od),
    .fb_div_o(fb), .out_div_o(od), .spread_o(ss));

  int total = 0, bad = 0;
  bit done = 0;
  logic [8:0] e_fb = 9'h100;
  logic [1:0] e_od = 2'd0;
  logic [7:0] e_ss = 8'd0;
  logic [7:0] tx [8];
  logic ack [9];

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(H/2); scl = 1'b1; wt(H/2);
    sda_m = 1'b0; wt(H/2); scl = 1'b0; wt(H/2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(H/2); scl = 1'b1; wt(H/2);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(H/2); scl = 1'b1; wt(H); scl = 1'b0; wt(H/2);
    end
    sda_m = 1'b1; wt(H/2); scl = 1'b1; wt(H/2);
    a = sda_pull;
    wt(H/2); scl = 1'b0; wt(H/2);
  endtask

  function automatic logic [7:0] addr_byte(input logic sel, input logic rw);
    return {5'b11011, sel, 1'b0, rw};
  endfunction

  // send address then n bytes from tx; ack[0] for address
  task automatic xfer(input logic [7:0] a, input int n, input bit do_stop);
    logic k;
    bus_start();
    send_byte(a, k); ack[0] = k;
    for (int i = 0; i < n; i++) begin
      send_byte(tx[i], k); ack[i+1] = k;
    end
    if (do_stop) bus_stop();
  endtask

  task automatic check_out(input string req);
    wt(10);
    check({req, " fb"}, 32'(fb), 32'(e_fb));
    check({req, " od"}, 32'(od), 32'(e_od));
    check({req, " ss"}, 32'(ss), 32'(e_ss));
  endtask

  task automatic model_commit();
    e_od = tx[1][7:6];
    e_fb = {tx[1][5:0], tx[2][7:5]};
    e_ss = tx[3];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    wt(5); rst = 1'b0; wt(3);
    // R1 reset state
    check("R1 fb", 32'(fb), 32'h100);
    check("R1 od", 32'(od), 0);
    check("R1 ss", 32'(ss), 0);
    check("R1 sda", 32'(sda_pull), 0);

    // R2 R4 R5 directed full write
    tx[0] = 8'h5A; tx[1] = 8'b10_101100; tx[2] = 8'b011_10101; tx[3] = 8'hC3;
    xfer(addr_byte(1'b0, 1'b0), 4, 1'b0);
    check("R2 addr ack", 32'(ack[0]), 1);
    for (int i = 1; i <= 4; i++) check("R4 data ack", 32'(ack[i]), 1);
    check_out("R5 before stop");
    bus_stop(); model_commit();
    check_out("R4 R5 after stop");
    check("R4 fb value", 32'(fb), 32'h163);

    // R3 wrong address select and read bit
    addr_sel = 1'b1;
    tx[1] = 8'h01; tx[2] = 8'h00; tx[3] = 8'h11;
    xfer(addr_byte(1'b0, 1'b0), 4, 1'b1);
    check("R3 mismatch ack", 32'(ack[0] | ack[1] | ack[4]), 0);
    check_out("R3 mismatch");
    xfer(addr_byte(1'b1, 1'b1), 4, 1'b1);
    check("R3 read ack", 32'(ack[0] | ack[2]), 0);
    check_out("R3 read");
    // R2 second address accepted
    tx[1] = 8'h7F; tx[2] = 8'hE0; tx[3] = 8'h22;
    xfer(addr_byte(1'b1, 1'b0), 4, 1'b1); model_commit();
    check("R2 alt addr ack", 32'(ack[0]), 1);
    check_out("R2 alt");

    // R6 short write
    tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = 8'hFF;
    xfer(addr_byte(1'b1, 1'b0), 3, 1'b1);
    check_out("R6 short");

    // R7 overflow bytes
    tx[1] = 8'b01_000111; tx[2] = 8'b110_00000; tx[3] = 8'h44; tx[4] = 8'hFF; tx[5] = 8'hFF;
    xfer(addr_byte(1'b1, 1'b0), 6, 1'b1); model_commit();
    check("R7 fourth ack", 32'(ack[4]), 1);
    check("R7 fifth ack", 32'(ack[5]), 0);
    check("R7 sixth ack", 32'(ack[6]), 0);
    check_out("R7 overflow");

    // R11 repeated start
    tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = 8'h00;
    xfer(addr_byte(1'b1, 1'b0), 3, 1'b0);
    tx[1] = 8'b11_010101; tx[2] = 8'b101_11111; tx[3] = 8'h99;
    xfer(addr_byte(1'b1, 1'b0), 2, 1'b0);
    xfer(addr_byte(1'b1, 1'b0), 4, 1'b1); model_commit();
    check("R11 restart ack", 32'(ack[4]), 1);
    check_out("R11 restart");

    // R8 parallel passthrough
    ser_mode = 1'b0; par_fb = 9'h0A5; par_od = 2'd3; wt(2);
    check("R8 fb", 32'(fb), 32'h0A5);
    check("R8 od", 32'(od), 3);
    par_fb = 9'h1F0; par_od = 2'd1; wt(2);
    check("R8 fb 2", 32'(fb), 32'h1F0);
    e_fb = 9'h1F0; e_od = 2'd1;
    // R10 serial ignored while parallel
    tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = 8'h77;
    xfer(addr_byte(1'b1, 1'b0), 4, 1'b1);
    check("R10 no ack", 32'(ack[0]), 0);
    check_out("R10 ignored");
    // R9 latch on rise, hold
    ser_mode = 1'b1; wt(1); par_fb = 9'h003; par_od = 2'd2;
    check_out("R9 hold");
    tx[1] = 8'b00_111000; tx[2] = 8'b001_00000; tx[3] = 8'h05;
    xfer(addr_byte(1'b1, 1'b0), 4, 1'b1); model_commit();
    check_out("R9 commit after latch");

    // random mix
    for (int t = 0; t < 16; t++) begin
      logic sel, rw, hit;
      int n;
      sel = 1'($urandom);
      addr_sel = 1'($urandom);
      rw = ($urandom % 5) == 0;
      n = 1 + ($urandom % 6);
      for (int i = 0; i < 6; i++) tx[i] = 8'($urandom);
      xfer(addr_byte(sel, rw), n, 1'b1);
      hit = (sel == addr_sel) && !rw;
      check("R2 R3 rand addr ack", 32'(ack[0]), 32'(hit));
      for (int i = 1; i <= n; i++)
        check("R4 R7 rand data ack", 32'(ack[i]), 32'(hit && i <= 4));
      if (hit && n >= 4) model_commit();
      check_out("R5 R6 rand");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule